// File: doc/BRIEF.md
# I2S Channel-Select Shift-Latch Receiver

This block takes a serial I2S audio stream clocked by its own bit clock, 64 bit clocks per frame, and turns it into parallel 16-bit sample words for a resistor-ladder converter. An XOR of word-select with a static strap selects one channel. The serial bits of that channel's slot are shifted into a 32-stage chain. When the slot closes, the sample window of the chain is copied into the channel's output register.

The block has two update modes. In staggered mode only the strapped channel is captured, so left and right converters built from two instances update half a sample period apart. In simultaneous mode the full 64-bit frame is held in a doubled chain, and both output words change together at the boundary where word-select falls. Every update raises a one-cycle `word_valid` strobe.

The output side is a valid-only stream. The ladder cannot stall, so there is no ready input and no back-pressure. A word is held until it is replaced, and `word_valid` only marks the cycle in which it changes.

Top module: `i2s_ladder_rx`

## Requirements
- R1: A synchronous active-high `rst` clears `left_word`, `right_word` and `word_valid` to zero on the next rising clock edge.
- R2: `ws` low carries left data and `ws` high carries right data. In staggered mode (`stereo_mode`=0), bits are shifted only while `ws` equals `chan_sel`, and the captured word goes to `left_word` when `chan_sel`=0 and to `right_word` when `chan_sel`=1.
- R3: In staggered mode, an update is made at the first rising edge at which the sampled `ws` differs from `chan_sel` after a complete slot. The new word and `word_valid`=1 are visible in the cycle that follows that edge.
- R4: The bit sampled at the first edge of a slot is the delay bit and is discarded. The next 16 bits, MSB first, form the word.
- R5: The 15 bits sampled after the 16 word bits in a 32-bit slot have no effect on the output.
- R6: Outside update cycles both output words hold their values. In staggered mode the output of the channel that is not selected never changes.
- R7: In simultaneous mode (`stereo_mode`=1), both words update at the first edge where `ws` is sampled low after being sampled high. `left_word` comes from the preceding `ws`-low slot and `right_word` from the following `ws`-high slot, and `chan_sel` has no effect.
- R8: `word_valid` is high for exactly one cycle per update. A simultaneous-mode update of both words gives one strobe.
- R9: After reset or a mode change, no update is made until a complete slot (staggered) or a complete frame (simultaneous) has been shifted in. A partial first slot produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word-select: 0 left slot, 1 right slot |
| sdata | input | 1 | Serial audio data, MSB first |
| chan_sel | input | 1 | Static strap: 0 captures left, 1 captures right (staggered mode) |
| stereo_mode | input | 1 | 0 staggered per-channel update, 1 simultaneous update of both words |
| left_word | output | 16 | Latched left sample |
| right_word | output | 16 | Latched right sample |
| word_valid | output | 1 | One-cycle strobe in the cycle an output word changes |

## Verification
The assertions assume that `ws` changes only on 32-bit slot boundaries, which keeps successive strobes far apart. They also assume that `chan_sel` and `stereo_mode` change only between slots, so the mode sampled one cycle before a strobe is the mode that caused it. The bench builds all stimulus from whole 32-bit slots, with at most one extra idle or trailing bit. It changes the strap and mode only just after a clock edge that closes a frame, or while reset is held. The only short slot is the one applied deliberately after reset.

// File: rtl/i2slr_pkg.sv
package i2slr_pkg;

  // Update policy selected by the stereo_mode pin.
  typedef enum logic {
    UPD_STAGGER = 1'b0,
    UPD_STEREO  = 1'b1
  } upd_mode_e;

  // Per-edge control events produced by the gate stage.
  typedef struct packed {
    logic stag_shift;  // staggered mode, selected slot active
    logic stag_end;    // staggered mode, selected slot just closed
    logic frame_end;   // simultaneous mode, word-select fell
    logic mode_flip;   // mode differs from previous edge
  } gate_evt_t;

endpackage

// File: rtl/i2slr_gate.sv
module i2slr_gate
  import i2slr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ws,
  input  logic      chan_sel,
  input  upd_mode_e mode,
  output gate_evt_t evt
);

  logic      x_now;
  logic      x_r;
  logic      ws_r;
  upd_mode_e mode_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_r    <= 1'b1;
      ws_r   <= 1'b0;
      mode_r <= UPD_STAGGER;
    end else begin
      x_r    <= x_now;
      ws_r   <= ws;
      mode_r <= mode;
    end
  end

  always_comb begin
    x_now          = ws ^ chan_sel;
    evt.stag_shift = (mode == UPD_STAGGER) && !x_now;
    evt.stag_end   = (mode == UPD_STAGGER) && x_now && !x_r;
    evt.frame_end  = (mode == UPD_STEREO) && !ws && ws_r;
    evt.mode_flip  = (mode != mode_r);
  end

endmodule

// File: rtl/i2slr_fill_count.sv
module i2slr_fill_count
  import i2slr_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  upd_mode_e mode,
  input  gate_evt_t evt,
  output logic      full
);

  localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;
  localparam int unsigned CW         = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] SLOT_CNT  = CW'(SLOT_BITS);
  localparam logic [CW-1:0] FRAME_CNT = CW'(FRAME_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || evt.mode_flip) begin
      cnt <= '0;
    end else if (mode == UPD_STEREO) begin
      if (evt.frame_end)          cnt <= CW'(1);
      else if (cnt != FRAME_CNT)  cnt <= cnt + 1'b1;
    end else begin
      if (!evt.stag_shift)        cnt <= '0;
      else if (cnt != SLOT_CNT)   cnt <= cnt + 1'b1;
    end
  end

  assign full = (mode == UPD_STEREO) ? (cnt == FRAME_CNT) : (cnt == SLOT_CNT);

  // R9
  stag_full_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == UPD_STAGGER && full) |-> $past(evt.stag_shift));

endmodule

// File: rtl/i2slr_chain.sv
module i2slr_chain
  import i2slr_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  upd_mode_e                mode,
  input  logic                     stag_shift,
  input  logic                     sd,
  output logic [2*SLOT_BITS-1:0]   chain
);

  logic [SLOT_BITS-1:0] half [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic en;
    logic din;
    if (h == 0) begin : g_lo
      assign en  = (mode == UPD_STEREO) || stag_shift;
      assign din = sd;
    end else begin : g_hi
      assign en  = (mode == UPD_STEREO);
      assign din = half[0][SLOT_BITS-1];
    end
    always_ff @(posedge clk) begin
      if (rst)     half[h] <= '0;
      else if (en) half[h] <= {half[h][SLOT_BITS-2:0], din};
    end
  end

  assign chain = {half[1], half[0]};

  // R2
  hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == UPD_STAGGER) |=> $stable(half[1]));

endmodule

// File: rtl/i2slr_out_latch.sv
module i2slr_out_latch
  import i2slr_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd,
  input  upd_mode_e              mode,
  input  logic                   chan_sel,
  input  logic [2*SLOT_BITS-1:0] chain,
  output logic [WORD_BITS-1:0]   left_word,
  output logic [WORD_BITS-1:0]   right_word,
  output logic                   word_valid
);

  localparam int unsigned LO_TOP = SLOT_BITS - 2;
  localparam int unsigned HI_TOP = 2 * SLOT_BITS - 2;

  logic [WORD_BITS-1:0] lo_win;
  logic [WORD_BITS-1:0] hi_win;

  assign lo_win = chain[LO_TOP -: WORD_BITS];
  assign hi_win = chain[HI_TOP -: WORD_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= upd;
      if (upd) begin
        if (mode == UPD_STEREO) begin
          left_word  <= hi_win;
          right_word <= lo_win;
        end else if (chan_sel) begin
          right_word <= lo_win;
        end else begin
          left_word  <= lo_win;
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !$past(rst)) |-> $stable({left_word, right_word}));

endmodule

// File: rtl/i2s_ladder_rx.sv
module i2s_ladder_rx
  import i2slr_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ws,
  input  logic                 sdata,
  input  logic                 chan_sel,
  input  logic                 stereo_mode,
  output logic [WORD_BITS-1:0] left_word,
  output logic [WORD_BITS-1:0] right_word,
  output logic                 word_valid
);

  upd_mode_e              mode;
  gate_evt_t              evt;
  logic                   full;
  logic                   upd;
  logic [2*SLOT_BITS-1:0] chain;

  assign mode = upd_mode_e'(stereo_mode);

  i2slr_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .ws       (ws),
    .chan_sel (chan_sel),
    .mode     (mode),
    .evt      (evt)
  );

  i2slr_fill_count #(.SLOT_BITS(SLOT_BITS)) u_count (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .evt  (evt),
    .full (full)
  );

  i2slr_chain #(.SLOT_BITS(SLOT_BITS)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .stag_shift (evt.stag_shift),
    .sd         (sdata),
    .chain      (chain)
  );

  assign upd = full && !evt.mode_flip && (evt.stag_end || evt.frame_end);

  i2slr_out_latch #(.SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .upd        (upd),
    .mode       (mode),
    .chan_sel   (chan_sel),
    .chain      (chain),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid)
  );

  // R3
  stag_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !$past(stereo_mode)) |->
      ($past(ws ^ chan_sel) && !$past(ws ^ chan_sel, 2)));

  // R7
  stereo_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && $past(stereo_mode)) |-> (!$past(ws) && $past(ws, 2)));

endmodule

// File: tb/i2s_ladder_rx_test.sv
module i2s_ladder_rx_test;

  localparam int SLOT = 32;
  localparam int WB   = 16;

  // {fill, stereo_mode, chan_sel, left, right}
  localparam logic [34:0] VECS [8] = '{
    {1'b1, 1'b0, 1'b0, 16'h0000, 16'hFFFF},  // R4 R5: fill ones ignored
    {1'b0, 1'b0, 1'b1, 16'hA5C3, 16'hFFFF},
    {1'b1, 1'b0, 1'b1, 16'h1234, 16'h8001},
    {1'b0, 1'b0, 1'b0, 16'h8001, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h5A5A, 16'h0F0F},
    {1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0001},
    {1'b1, 1'b0, 1'b0, 16'h7FFE, 16'h1111},
    {1'b0, 1'b0, 1'b1, 16'h2222, 16'hC3C3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws = 1'b1;
  logic sdata = 1'b0;
  logic chan_sel = 1'b0;
  logic stereo_mode = 1'b0;
  logic [WB-1:0] left_word;
  logic [WB-1:0] right_word;
  logic word_valid;

  int checks = 0;
  int fails = 0;
  int pulse_cnt = 0;
  int width_err = 0;
  int hold_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic prev_valid = 1'b0;
  logic [2*WB-1:0] prev_out = '0;

  logic vf, vm, vs;
  logic [WB-1:0] vl, vr, exp_l, exp_r;
  int base;

  always #2 clk = ~clk;

  i2s_ladder_rx uut (
    .clk         (clk),
    .rst         (rst),
    .ws          (ws),
    .sdata       (sdata),
    .chan_sel    (chan_sel),
    .stereo_mode (stereo_mode),
    .left_word   (left_word),
    .right_word  (right_word),
    .word_valid  (word_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) pulse_cnt++;
      if (word_valid && prev_valid) width_err++;
      if (!word_valid && {left_word, right_word} != prev_out) hold_err++;
    end
    prev_valid = word_valid;
    prev_out   = {left_word, right_word};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [WB-1:0] act, logic [WB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic w, logic b);
    @(negedge clk);
    ws = w;
    sdata = b;
  endtask

  task automatic send_slot(logic w, logic [WB-1:0] word, logic f);
    for (int t = 0; t < SLOT; t++) begin
      if (t >= 1 && t <= WB) send_bit(w, word[WB-t]);
      else                   send_bit(w, f);
    end
  endtask

  task automatic send_frame(logic [WB-1:0] l, logic [WB-1:0] r, logic f);
    send_slot(1'b0, l, f);
    send_slot(1'b1, r, f);
  endtask

  task automatic do_reset(logic m, logic s);
    @(negedge clk);
    rst = 1'b1;
    ws = 1'b1;
    stereo_mode = m;
    chan_sel = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 left_word in reset", left_word, '0);
    chk("R1 right_word in reset", right_word, '0);
    chk_int("R1 word_valid in reset", int'(word_valid), 0);
    rst = 1'b0;
    exp_l = '0;
    exp_r = '0;

    // Vector table walk: three frames per entry
    for (int v = 0; v < 8; v++) begin
      {vf, vm, vs, vl, vr} = VECS[v];
      @(posedge clk);
      #1;
      stereo_mode = vm;
      chan_sel = vs;
      for (int k = 0; k < 3; k++) send_frame(vl, vr, vf);
      if (vm) begin
        exp_l = vl;
        exp_r = vr;
      end else if (vs) begin
        exp_r = vr;
      end else begin
        exp_l = vl;
      end
      if (vm) begin
        chk("R7 stereo left_word", left_word, exp_l);
        chk("R7 stereo right_word", right_word, exp_r);
      end else begin
        chk("R2 R4 R5 staggered left_word", left_word, exp_l);
        chk("R2 R6 staggered right_word", right_word, exp_r);
      end
    end

    // R3 R4: exact update cycle, delay bit set to one
    do_reset(1'b0, 1'b0);
    send_slot(1'b0, 16'hBEEF, 1'b1);
    send_bit(1'b1, 1'b1);
    chk_int("R3 valid before closing edge", int'(word_valid), 0);
    chk("R3 left before closing edge", left_word, '0);
    @(posedge clk);
    #1;
    chk_int("R3 valid after closing edge", int'(word_valid), 1);
    chk("R3 R4 left after closing edge", left_word, 16'hBEEF);
    @(posedge clk);
    #1;
    chk_int("R8 valid drops next cycle", int'(word_valid), 0);

    // R9: partial first slot after reset gives no update
    do_reset(1'b0, 1'b0);
    base = pulse_cnt;
    for (int t = 0; t < 20; t++) send_bit(1'b0, 1'b1);
    send_slot(1'b1, 16'h0000, 1'b1);
    repeat (2) @(negedge clk);
    chk_int("R9 no strobe after partial slot", pulse_cnt - base, 0);
    chk("R9 left held after partial slot", left_word, '0);
    send_slot(1'b0, 16'h3C96, 1'b0);
    send_slot(1'b1, 16'h0000, 1'b0);
    chk("R9 left after first complete slot", left_word, 16'h3C96);

    // R8 R6: staggered right channel strobe count
    do_reset(1'b0, 1'b1);
    base = pulse_cnt;
    for (int k = 0; k < 3; k++) send_frame(16'h1111, 16'h6E6E, 1'b1);
    send_bit(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_int("R8 staggered strobe count", pulse_cnt - base, 3);
    chk("R2 right selected", right_word, 16'h6E6E);
    chk("R6 unselected left untouched", left_word, '0);

    // R7 R8: simultaneous update, one strobe per frame
    do_reset(1'b1, 1'b0);
    base = pulse_cnt;
    for (int k = 0; k < 4; k++) send_frame(16'hABCD, 16'h1357, 1'b0);
    send_bit(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_int("R8 stereo strobe count", pulse_cnt - base, 4);
    chk("R7 stereo left", left_word, 16'hABCD);
    chk("R7 stereo right", right_word, 16'h1357);

    chk_int("R8 strobe width errors", width_err, 0);
    chk_int("R6 hold errors", hold_err, 0);

    // R1: reset during operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 left cleared", left_word, '0);
    chk("R1 right cleared", right_word, '0);
    chk_int("R1 valid cleared", int'(word_valid), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule